// File: doc/BRIEF.md
# Vector Length State Register

This block keeps the vector-length state of a scalar core that has been extended to run vector loops, and serves the CSR accesses that read and change it. It holds four 6-bit fields: the maximum vector length, the active vector length, a source element offset and a destination element offset. The core uses the packed path to save and restore the whole state with ordinary CSR semantics. It uses the length-only path to set the active length in one instruction and get the resulting length back.

Each access names a path (`csr_sel`) and an operation (`csr_op`). The write data is either the full register operand or a 5-bit immediate. Every write is clamped in a chain. The maximum length is limited by the register width. The active length is limited by the clamped maximum. Both offsets are limited by the clamped active length. As a result, the stored state always satisfies these bounds.

Top module: `vstate_csr`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, all four fields read zero.
- R2: The packed path places the destination offset at bits 23:18, the source offset at 17:12, the active length at 11:6 and the maximum length at 5:0. Bits above 23 read as zero, and write data in bits above 23 has no effect.
- R3: A packed write stores the maximum length as the smaller of its field value and XLEN-1.
- R4: A packed write stores the active length as the smaller of its field value and the clamped maximum length.
- R5: After any write, each offset is no larger than the newly stored active length. A packed write takes the smaller of the field value and that length. A length-only write keeps an offset unless it exceeds the new length, in which case the offset becomes the new length.
- R6: `csr_op` selects 00 read, 01 write (swap), 10 set bits, 11 clear bits. On the packed path, `rdata` returns the contents held before the access, as a standard CSR does.
- R7: On the length-only path, a write, set or clear returns the new clamped active length on `rdata`. This value is the operand combined with the current length, then limited to the current maximum. A read returns the current length.
- R8: A length-only write leaves the maximum length unchanged.
- R9: When `use_imm` is high, the operand is `wdata[4:0]` zero-extended, so it can only take values 0 to 31.
- R10: With `csr_en` low, or with `csr_op` = 00, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | Access valid this cycle |
| csr_sel | input | 1 | 0 = packed state path, 1 = length-only path |
| csr_op | input | 2 | 00 read, 01 write, 10 set, 11 clear |
| use_imm | input | 1 | Operand is the 5-bit immediate in `wdata[4:0]` |
| wdata | input | XLEN | Register operand or immediate |
| rdata | output | XLEN | Value returned to the destination register |
| maxvl | output | 6 | Current maximum vector length |
| vl | output | 6 | Current active vector length |
| src_offs | output | 6 | Current source element offset |
| dst_offs | output | 6 | Current destination element offset |

## Verification
The bench builds two copies of the block side by side, one with XLEN = 32 and one with XLEN = 64, and drives both with the same accesses. With XLEN = 32, maximum-length values from 32 to 63 fit in the 6-bit field but must clamp to 31, which exercises R3. With XLEN = 64 the clamp never bites, and length-only operands with bits set above bit 31 must still be limited to the maximum. Running both copies on identical stimulus shows where the two register widths diverge.

// File: rtl/vstate_csr.sv
module vstate_csr #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_en,
  input  logic            csr_sel,
  input  logic [1:0]      csr_op,
  input  logic            use_imm,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata,
  output logic [5:0]      maxvl,
  output logic [5:0]      vl,
  output logic [5:0]      src_offs,
  output logic [5:0]      dst_offs
);
  localparam int FW = 6;
  localparam int PW = 4 * FW;
  localparam logic [FW-1:0] CAP = FW'(XLEN - 1);

  function automatic logic [FW-1:0] lim(input logic [FW-1:0] a, input logic [FW-1:0] b);
    return (a > b) ? b : a;
  endfunction

  logic [XLEN-1:0] opnd, vl_raw;
  logic [PW-1:0]   pk_old, pk_raw;
  logic [FW-1:0]   m_n, v_n, s_n, d_n, vv_n;
  logic            wr;

  assign wr     = csr_en && (csr_op != 2'b00);
  assign opnd   = use_imm ? XLEN'(wdata[4:0]) : wdata;
  assign pk_old = {dst_offs, src_offs, vl, maxvl};

  always_comb begin
    case (csr_op)
      2'b10:   pk_raw = pk_old | opnd[PW-1:0];
      2'b11:   pk_raw = pk_old & ~opnd[PW-1:0];
      default: pk_raw = opnd[PW-1:0];
    endcase
    case (csr_op)
      2'b10:   vl_raw = XLEN'(vl) | opnd;
      2'b11:   vl_raw = XLEN'(vl) & ~opnd;
      default: vl_raw = opnd;
    endcase
  end

  assign m_n  = lim(pk_raw[FW-1:0], CAP);
  assign v_n  = lim(pk_raw[2*FW-1:FW], m_n);
  assign s_n  = lim(pk_raw[3*FW-1:2*FW], v_n);
  assign d_n  = lim(pk_raw[4*FW-1:3*FW], v_n);
  assign vv_n = (vl_raw > XLEN'(maxvl)) ? maxvl : vl_raw[FW-1:0];

  assign rdata = csr_sel ? XLEN'(wr ? vv_n : vl) : XLEN'(pk_old);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maxvl    <= '0;
      vl       <= '0;
      src_offs <= '0;
      dst_offs <= '0;
    end else if (wr) begin
      if (csr_sel) begin
        vl       <= vv_n;
        src_offs <= lim(src_offs, vv_n);
        dst_offs <= lim(dst_offs, vv_n);
      end else begin
        maxvl    <= m_n;
        vl       <= v_n;
        src_offs <= s_n;
        dst_offs <= d_n;
      end
    end
  end
endmodule

// File: rtl/vstate_csr_sva.sv
module vstate_csr_sva #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_en,
  input logic            csr_sel,
  input logic [1:0]      csr_op,
  input logic            use_imm,
  input logic [XLEN-1:0] wdata,
  input logic [XLEN-1:0] rdata,
  input logic [5:0]      maxvl,
  input logic [5:0]      vl,
  input logic [5:0]      src_offs,
  input logic [5:0]      dst_offs
);
  a_r3_max_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(maxvl) <= XLEN - 1);

  a_r4_vl_le_max: assert property (@(posedge clk) disable iff (!rst_n)
    vl <= maxvl);

  a_r5_offs_le_vl: assert property (@(posedge clk) disable iff (!rst_n)
    (src_offs <= vl) && (dst_offs <= vl));

  a_r7_vl_returns_new: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_sel && csr_op != 2'b00) |=> (XLEN'(vl) == $past(rdata)));

  a_r8_max_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_sel) |=> $stable(maxvl));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_en || csr_op == 2'b00) |=>
      ($stable(maxvl) && $stable(vl) && $stable(src_offs) && $stable(dst_offs)));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_sel |-> (rdata >> 24) == '0);
endmodule

bind vstate_csr vstate_csr_sva #(.XLEN(XLEN)) u_sva (.*);

// File: tb/vstate_csr_bench.sv
module vstate_csr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sel = 1'b0, imm = 1'b0;
  logic [1:0] op = 2'b00;
  logic [63:0] wd = '0;
  logic [31:0] rd32;
  logic [63:0] rd64;
  logic [5:0] mx32, v32, s32, d32, mx64, v64, s64, d64;
  int checks = 0, fails = 0;
  int m_mx[2], m_v[2], m_s[2], m_d[2];
  bit done = 1'b0;

  always #5 clk = ~clk;

  vstate_csr #(.XLEN(32)) u_vstate_csr (
    .clk(clk), .rst_n(rst_n), .csr_en(en), .csr_sel(sel), .csr_op(op),
    .use_imm(imm), .wdata(wd[31:0]), .rdata(rd32),
    .maxvl(mx32), .vl(v32), .src_offs(s32), .dst_offs(d32));

  vstate_csr #(.XLEN(64)) u_vstate_csr_x64 (
    .clk(clk), .rst_n(rst_n), .csr_en(en), .csr_sel(sel), .csr_op(op),
    .use_imm(imm), .wdata(wd), .rdata(rd64),
    .maxvl(mx64), .vl(v64), .src_offs(s64), .dst_offs(d64));

  function automatic logic [63:0] model(input int xl, input logic s_path,
      input logic [1:0] o, input logic im, input logic [63:0] w,
      inout int mx, inout int v, inout int s, inout int d);
    logic [63:0] opd, old, nw;
    opd = im ? {59'd0, w[4:0]} : ((xl == 64) ? w : {32'd0, w[31:0]});
    if (!s_path) begin
      old = (64'(d) << 18) | (64'(s) << 12) | (64'(v) << 6) | 64'(mx);
      model = old;
      if (o != 2'b00) begin
        nw = (o == 2'b01) ? opd : (o == 2'b10) ? (old | opd) : (old & ~opd);
        mx = int'(nw[5:0]);   if (mx > xl - 1) mx = xl - 1;
        v  = int'(nw[11:6]);  if (v > mx) v = mx;
        s  = int'(nw[17:12]); if (s > v) s = v;
        d  = int'(nw[23:18]); if (d > v) d = v;
      end
    end else begin
      model = 64'(v);
      if (o != 2'b00) begin
        old = 64'(v);
        nw = (o == 2'b01) ? opd : (o == 2'b10) ? (old | opd) : (old & ~opd);
        if ((xl == 32) && (o == 2'b11)) nw = nw & 64'hFFFF_FFFF;
        v = (nw > 64'(mx)) ? mx : int'(nw[5:0]);
        if (s > v) s = v;
        if (d > v) d = v;
        model = 64'(v);
      end
    end
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_state(input string tag);
    chk({tag, " x32 maxvl"}, 64'(mx32), 64'(m_mx[0]));
    chk({tag, " x32 vl"},    64'(v32),  64'(m_v[0]));
    chk({tag, " x32 src"},   64'(s32),  64'(m_s[0]));
    chk({tag, " x32 dst"},   64'(d32),  64'(m_d[0]));
    chk({tag, " x64 maxvl"}, 64'(mx64), 64'(m_mx[1]));
    chk({tag, " x64 vl"},    64'(v64),  64'(m_v[1]));
    chk({tag, " x64 src"},   64'(s64),  64'(m_s[1]));
    chk({tag, " x64 dst"},   64'(d64),  64'(m_d[1]));
  endtask

  task automatic access(input string tag, input logic e, input logic sp,
      input logic [1:0] o, input logic im, input logic [63:0] w);
    int tmx[2], tv[2], ts[2], td[2];
    logic [63:0] er[2];
    @(negedge clk);
    en = e; sel = sp; op = o; imm = im; wd = w;
    for (int k = 0; k < 2; k++) begin
      tmx[k] = m_mx[k]; tv[k] = m_v[k]; ts[k] = m_s[k]; td[k] = m_d[k];
      er[k] = model(k == 0 ? 32 : 64, sp, e ? o : 2'b00, im, w, tmx[k], tv[k], ts[k], td[k]);
    end
    #1;
    chk({tag, " x32 rdata"}, {32'd0, rd32}, er[0]);
    chk({tag, " x64 rdata"}, rd64, er[1]);
    @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      m_mx[k] = tmx[k]; m_v[k] = tv[k]; m_s[k] = ts[k]; m_d[k] = td[k];
    end
    cmp_state(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    for (int k = 0; k < 2; k++) begin m_mx[k] = 0; m_v[k] = 0; m_s[k] = 0; m_d[k] = 0; end
    repeat (3) @(posedge clk);
    #1 cmp_state("R1 reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 cmp_state("R1 after reset");
    // R3 R4 R5: all-ones packed write clamps per width; R2 upper bits ignored
    access("R3 R4 R5 packed all-ones", 1, 0, 2'b01, 0, '1);
    access("R6 R2 packed read old", 1, 0, 2'b00, 0, '0);
    // R2 field layout: dst=3 src=5 vl=9 max=20
    access("R2 layout write", 1, 0, 2'b01, 0, 64'hFF00_0000 | (64'd3 << 18) | (64'd5 << 12) | (64'd9 << 6) | 64'd20);
    access("R6 swap returns old", 1, 0, 2'b01, 0, 64'd40);
    access("R2 layout write2", 1, 0, 2'b01, 0, (64'd30 << 18) | (64'd2 << 12) | (64'd12 << 6) | 64'd40);
    // R7 R5: length-only write lowers offsets, returns new value
    access("R7 R5 vl write", 1, 1, 2'b01, 0, 64'd1);
    access("R7 R8 vl write over max", 1, 1, 2'b01, 0, 64'h1_0000_0005);
    access("R9 immediate", 1, 1, 2'b01, 1, 64'hFFFF_FFE7);
    access("R7 vl clear", 1, 1, 2'b11, 0, 64'd4);
    access("R7 vl set", 1, 1, 2'b10, 0, 64'd2);
    access("R10 disabled write", 0, 0, 2'b01, 0, 64'd0);
    access("R10 read op", 1, 1, 2'b00, 0, 64'd0);
    access("R6 packed set", 1, 0, 2'b10, 0, 64'd1 << 12);
    access("R6 packed clear", 1, 0, 2'b11, 0, 64'h3F);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] w;
      w = {$urandom(), $urandom()};
      if ($urandom_range(0, 1) == 0) w = w & 64'h00FF_FFFF;
      access("R3 R4 R5 R6 R7 R8 R9 R10 random", $urandom_range(0, 9) != 0,
             1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
             $urandom_range(0, 4) == 0, w);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule